// File: doc/BRIEF.md
# Masked-Write GPIO Bank

This block is one bank of 32 general-purpose pins behind a small register port. It keeps an output data register that software can replace whole, or update one half at a time through two write-only windows. Each window carries a 16-bit protect mask in its upper half and 16 data bits in its lower half. A data bit changes only where its mask bit is 0, so a single store can set or clear a group of pins without a read-modify-write. The bank also keeps a direction register and a separate output-enable register. A pin drives its pad only when both of its bits are set. Pin levels pass through a two-flop synchroniser and can be read from a read-only register.

Accesses use single-cycle strobes. A write takes effect at the clock edge that samples `wr_en`. A read sampled at one edge returns its data after that edge, and `rvalid` is high for that cycle. The read path is a two-state machine. `BUS_IDLE` moves to `BUS_READ` when `rd_en` is sampled high. `BUS_READ` stays in `BUS_READ` on a back-to-back read and returns to `BUS_IDLE` when no read is sampled. `rvalid` is high only in `BUS_READ`.

Register offsets are byte addresses on an 8-bit address. They are: 0x00 low masked window (write-only), 0x04 high masked window (write-only), 0x40 output data (read/write), 0x60 pin levels (read-only), 0x80 direction (read/write, 1 = output) and 0x84 output enable (read/write, 1 = enabled).

Top module: `gpio_bank`

## Requirements
- R1: After reset, every register is zero: `pad_out` = 0, `pad_oe` = 0, `rvalid` = 0, and reads of 0x40, 0x80 and 0x84 return 0.
- R2: A write to 0x40 replaces all 32 output data bits, and a read of 0x40 returns the stored value.
- R3: A write to 0x00 updates data bit i (i = 0..15) to `wdata[i]` only where `wdata[16+i]` is 0. Bits whose mask bit is 1 keep their value, and data bits 31:16 are unchanged.
- R4: A write to 0x04 updates data bit 16+i to `wdata[i]` only where `wdata[16+i]` is 0. Protected bits keep their value, and data bits 15:0 are unchanged.
- R5: Reads of 0x00 and 0x04 return zero.
- R6: `pad_out` equals the output data register. `pad_oe[i]` is 1 exactly when direction bit i and output-enable bit i are both 1.
- R7: Once direction bit 7 or bit 8 is 1, a write of 0 to that bit is ignored until reset. The other direction bits follow the written value.
- R8: A read of 0x60 returns `pad_in` delayed by two clock edges. Writes to 0x60 have no effect.
- R9: Read data appears in the cycle after the edge that samples `rd_en`, with `rvalid` = 1 for exactly that cycle. `rvalid` = 0 in a cycle that follows an edge with no read.
- R10: Reads of an unmapped address return zero, and writes to one change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| addr | input | 8 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid while `rvalid` is high |
| rvalid | output | 1 | High in the cycle after a sampled read |
| pad_in | input | 32 | Pin levels from the pads, asynchronous |
| pad_out | output | 32 | Output level for each pad |
| pad_oe | output | 32 | Drive enable for each pad |

## Verification
The assertions assume that `wr_en` and `rd_en` are never both high in the same cycle. They also assume that the address and write data are stable at the edge that samples a strobe, and that reset holds both strobes low. The bench drives every strobe for exactly one cycle from its negative-edge tasks and never issues a read and a write together. It changes `pad_in` only on a negative edge, so the two-edge synchroniser delay can be counted exactly with back-to-back reads.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int unsigned OFS_MASK_LO = 'h00;
    localparam int unsigned OFS_MASK_HI = 'h04;
    localparam int unsigned OFS_DATA    = 'h40;
    localparam int unsigned OFS_PINS    = 'h60;
    localparam int unsigned OFS_DIR     = 'h80;
    localparam int unsigned OFS_OE      = 'h84;

    typedef enum logic {
        BUS_IDLE = 1'b0,
        BUS_READ = 1'b1
    } bus_state_e;

    typedef struct packed {
        logic full;
        logic lo;
        logic hi;
        logic dir;
        logic oe;
    } wr_sel_t;

endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
    parameter int unsigned W      = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs #(
    parameter int unsigned   W         = 32,
    parameter logic [W-1:0]  LOCK_MASK = 'h180
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  gpio_bank_pkg::wr_sel_t wsel,
    input  logic [W-1:0]           wdata,
    output logic [W-1:0]           data_q,
    output logic [W-1:0]           dir_q,
    output logic [W-1:0]           oe_q
);
    localparam int unsigned HALF = W / 2;

    logic [W-1:0] data_d;
    logic [W-1:0] dir_d;
    logic [W-1:0] oe_d;

    always_comb begin
        data_d = data_q;
        if (wsel.full) begin
            data_d = wdata;
        end else if (wsel.lo) begin
            for (int i = 0; i < HALF; i++) begin
                if (!wdata[HALF+i]) data_d[i] = wdata[i];
            end
        end else if (wsel.hi) begin
            for (int i = 0; i < HALF; i++) begin
                if (!wdata[HALF+i]) data_d[HALF+i] = wdata[i];
            end
        end
    end

    always_comb begin
        dir_d = dir_q;
        oe_d  = oe_q;
        if (wsel.dir) dir_d = wdata | (dir_q & LOCK_MASK);
        if (wsel.oe)  oe_d  = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            dir_q  <= '0;
            oe_q   <= '0;
        end else begin
            data_q <= data_d;
            dir_q  <= dir_d;
            oe_q   <= oe_d;
        end
    end

    // R3: protected low bits and the whole upper half survive a low-window write
    a_r3_low_mask_keep: assert property (@(posedge clk) disable iff (!rst_n)
        wsel.lo |=> ((data_q[HALF-1:0] & $past(wdata[W-1:HALF])) ==
                     ($past(data_q[HALF-1:0]) & $past(wdata[W-1:HALF])))
                    && (data_q[W-1:HALF] == $past(data_q[W-1:HALF])));

    // R4: protected high bits and the whole lower half survive a high-window write
    a_r4_high_mask_keep: assert property (@(posedge clk) disable iff (!rst_n)
        wsel.hi |=> ((data_q[W-1:HALF] & $past(wdata[W-1:HALF])) ==
                     ($past(data_q[W-1:HALF]) & $past(wdata[W-1:HALF])))
                    && (data_q[HALF-1:0] == $past(data_q[HALF-1:0])));

    // R7: a locked direction bit that is set never clears
    a_r7_lock_hold: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((dir_q & $past(dir_q) & LOCK_MASK) == ($past(dir_q) & LOCK_MASK)));

endmodule

// File: rtl/gpio_bank_bus.sv
module gpio_bank_bus #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned W      = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic                   rd_en,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [W-1:0]           data_q,
    input  logic [W-1:0]           dir_q,
    input  logic [W-1:0]           oe_q,
    input  logic [W-1:0]           pin_q,
    output gpio_bank_pkg::wr_sel_t wsel,
    output logic [W-1:0]           rdata,
    output logic                   rvalid
);
    import gpio_bank_pkg::*;

    localparam logic [ADDR_W-1:0] A_LO   = ADDR_W'(OFS_MASK_LO);
    localparam logic [ADDR_W-1:0] A_HI   = ADDR_W'(OFS_MASK_HI);
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);
    localparam logic [ADDR_W-1:0] A_PINS = ADDR_W'(OFS_PINS);
    localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(OFS_DIR);
    localparam logic [ADDR_W-1:0] A_OE   = ADDR_W'(OFS_OE);

    bus_state_e   state_q, state_d;
    logic [W-1:0] rd_mux;
    logic [W-1:0] rdata_q;

    always_comb begin
        wsel      = '0;
        wsel.full = wr_en && (addr == A_DATA);
        wsel.lo   = wr_en && (addr == A_LO);
        wsel.hi   = wr_en && (addr == A_HI);
        wsel.dir  = wr_en && (addr == A_DIR);
        wsel.oe   = wr_en && (addr == A_OE);
    end

    always_comb begin
        unique case (addr)
            A_DATA:  rd_mux = data_q;
            A_PINS:  rd_mux = pin_q;
            A_DIR:   rd_mux = dir_q;
            A_OE:    rd_mux = oe_q;
            default: rd_mux = '0;
        endcase
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: state_d = rd_en ? BUS_READ : BUS_IDLE;
            BUS_READ: state_d = rd_en ? BUS_READ : BUS_IDLE;
            default:  state_d = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rdata_q <= '0;
        else if (rd_en) rdata_q <= rd_mux;
    end

    always_comb begin
        rvalid = (state_q == BUS_READ);
        rdata  = rdata_q;
    end

    // R9: a sampled read gives valid data in the next cycle
    a_r9_rvalid_after_rd: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rvalid);

    // R9: no read, no valid
    a_r9_rvalid_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rvalid);

    // R5: masked windows read as zero
    a_r5_window_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && ((addr == A_LO) || (addr == A_HI)) |=> (rdata == '0));

    // R10: no write strobe reaches a register from an unmapped address
    a_r10_unmapped_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (addr != A_DATA) && (addr != A_LO) && (addr != A_HI) &&
        (addr != A_DIR) && (addr != A_OE) |-> (wsel == '0));

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned W      = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wdata,
    output logic [W-1:0]      rdata,
    output logic              rvalid,
    input  logic [W-1:0]      pad_in,
    output logic [W-1:0]      pad_out,
    output logic [W-1:0]      pad_oe
);
    import gpio_bank_pkg::*;

    localparam int unsigned  SYNC_STAGES = 2;
    localparam logic [W-1:0] LOCKED_PINS = W'('h180);

    wr_sel_t      wsel;
    logic [W-1:0] data_q;
    logic [W-1:0] dir_q;
    logic [W-1:0] oe_q;
    logic [W-1:0] pin_q;

    gpio_bank_bus #(.ADDR_W(ADDR_W), .W(W)) u_bus (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .addr   (addr),
        .data_q (data_q),
        .dir_q  (dir_q),
        .oe_q   (oe_q),
        .pin_q  (pin_q),
        .wsel   (wsel),
        .rdata  (rdata),
        .rvalid (rvalid)
    );

    gpio_bank_regs #(.W(W), .LOCK_MASK(LOCKED_PINS)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wsel   (wsel),
        .wdata  (wdata),
        .data_q (data_q),
        .dir_q  (dir_q),
        .oe_q   (oe_q)
    );

    gpio_bank_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pin_q)
    );

    assign pad_out = data_q;
    assign pad_oe  = dir_q & oe_q;

    // R6: a driving pad always has its direction bit set
    a_r6_drive_needs_dir: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & ~dir_q) == '0);

    // R6: a driving pad always has its output-enable bit set
    a_r6_drive_needs_oe: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & ~oe_q) == '0);

endmodule

// File: tb/tb_gpio_bank.sv
module tb_gpio_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rvalid;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    gpio_bank dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    typedef struct packed {
        logic        rd;
        logic [7:0]  a;
        logic [31:0] d;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'h40, 32'hA5A5_1234, 32'h0,         4'd2},  // R2 full write
        '{1'b1, 8'h40, 32'h0,         32'hA5A5_1234, 4'd2},  // R2 readback
        '{1'b0, 8'h00, 32'hFF00_00CD, 32'h0,         4'd3},  // R3 low byte open
        '{1'b1, 8'h40, 32'h0,         32'hA5A5_12CD, 4'd3},
        '{1'b0, 8'h04, 32'h0F0F_1234, 32'h0,         4'd4},  // R4 alternating nibbles
        '{1'b1, 8'h40, 32'h0,         32'h1535_12CD, 4'd4},
        '{1'b1, 8'h00, 32'h0,         32'h0,         4'd5},  // R5 low window reads 0
        '{1'b1, 8'h04, 32'h0,         32'h0,         4'd5},  // R5 high window reads 0
        '{1'b0, 8'h00, 32'hFFFF_0000, 32'h0,         4'd3},  // R3 all protected
        '{1'b0, 8'h04, 32'hFFFF_0000, 32'h0,         4'd4},  // R4 all protected
        '{1'b1, 8'h40, 32'h0,         32'h1535_12CD, 4'd3},
        '{1'b0, 8'hFC, 32'hFFFF_FFFF, 32'h0,         4'd10}, // R10 unmapped write
        '{1'b1, 8'h40, 32'h0,         32'h1535_12CD, 4'd10},
        '{1'b1, 8'hFC, 32'h0,         32'h0,         4'd10}  // R10 unmapped read
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic do_read(input logic [7:0] a, output logic [31:0] d, output logic v);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata; v = rvalid;
    endtask

    initial begin : watchdog
        #(200000 * 20);
        if (!done) begin
            checks++; failures++;
            $display("FAIL R9 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] r;
        logic        v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 pad_out", pad_out, 32'h0);
        check("R1 pad_oe", pad_oe, 32'h0);
        check("R1 rvalid", {31'h0, rvalid}, 32'h0);
        do_read(8'h40, r, v); check("R1 data", r, 32'h0);
        do_read(8'h80, r, v); check("R1 dir", r, 32'h0);
        do_read(8'h84, r, v); check("R1 oe", r, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].rd) begin
                do_read(VECS[i].a, r, v);
                checks++;
                if (r !== VECS[i].exp) begin
                    failures++;
                    $display("FAIL R%0d vector %0d actual=%h expected=%h",
                             VECS[i].req, i, r, VECS[i].exp);
                end
            end else begin
                do_write(VECS[i].a, VECS[i].d);
            end
        end

        // R6 gating and pad_out
        do_write(8'h80, 32'h0000_00F0);
        do_write(8'h84, 32'h0000_0030);
        @(negedge clk);
        check("R6 pad_oe", pad_oe, 32'h0000_0030);
        check("R6 pad_out", pad_out, 32'h1535_12CD);
        do_write(8'h84, 32'hFFFF_FFFF);
        @(negedge clk);
        check("R6 pad_oe dir-limited", pad_oe, 32'h0000_00F0);

        // R7 locked direction bits
        do_write(8'h80, 32'h0000_0080);
        do_write(8'h80, 32'h0000_0000);
        do_read(8'h80, r, v); check("R7 bit7 held", r, 32'h0000_0080);
        do_write(8'h80, 32'h0000_0100);
        do_read(8'h80, r, v); check("R7 bit8 added", r, 32'h0000_0180);
        do_write(8'h80, 32'h0001_0000);
        do_read(8'h80, r, v); check("R7 others follow", r, 32'h0001_0180);

        // R8 synchroniser delay, R9 read timing
        @(negedge clk);
        pad_in = 32'hDEAD_BEEF;
        rd_en = 1'b1; addr = 8'h60;
        @(negedge clk); check("R8 delay edge1", rdata, 32'h0);
        check("R9 rvalid", {31'h0, rvalid}, 32'h1);
        @(negedge clk); check("R8 delay edge2", rdata, 32'h0);
        @(negedge clk); check("R8 delay edge3", rdata, 32'hDEAD_BEEF);
        rd_en = 1'b0;
        @(negedge clk); check("R9 rvalid drops", {31'h0, rvalid}, 32'h0);
        do_write(8'h60, 32'h0);
        do_read(8'h60, r, v); check("R8 write ignored", r, 32'hDEAD_BEEF);
        check("R9 rvalid on read", {31'h0, v}, 32'h1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule